// File: doc/BRIEF.md
# Boot Command Handshake Controller

This block sequences the command bytes of a serial boot loader at byte level. It receives bytes from a UART through a valid strobe and returns one-cycle response bytes for the UART to send. It keeps a sticky record of three set-up steps: target selection, clock-mode selection and line-rate selection. An outside validator judges the parameters of each step and reports its verdict on `selOk`.

A line-rate change follows a fixed handshake. The controller acknowledges at the current rate and asks an outside timer for a one-bit wait. It then asks the UART to load the new rate and waits for a confirmation byte at that rate. A wrong confirmation byte restores the earlier rate and returns an error byte. The command that enters the programming/erasing state is refused until all three set-up steps are recorded. Once accepted, it erases the user area and then the user boot area, one request at a time, and acknowledges after both are finished.

Top module: `boot_handshake`

## Requirements
- R1: After reset, `txValid` is 0, `selFlags` is 0, `rateSel` is 0 (current rate), `progState` is 0, and every request output is 0.
- R2: In idle, the target-select byte 0x10 and the clock-select byte 0x11 with `selOk` high send 0x06 one cycle later and set `selFlags` bit 0 or bit 1. With `selOk` low they send 0xFF and leave the flag clear.
- R3: In idle, the rate-select byte 0x3F with `selOk` high sends 0x06 while `rateSel` is still 0. `waitReq` rises in the same cycle and stays high until `waitDone`.
- R4: `waitDone` sets `rateSel` to 1 and raises `rateReq` in the next cycle. `rateReq` stays high until `rateDone`, then falls.
- R5: While awaiting confirmation, byte 0x06 is answered with 0x06, sets `selFlags` bit 2, and keeps `rateSel` at 1.
- R6: While awaiting confirmation, any other byte clears `rateSel` and raises `rateReq` until `rateDone`. The controller then sends 0xFF and leaves `selFlags` bit 2 clear.
- R7: Byte 0x40 received while any `selFlags` bit is clear sends 0xFF and raises no erase request.
- R8: Byte 0x40 received with all three flags set raises `eraseUserReq` until `eraseUserDone`, then `eraseBootReq` until `eraseBootDone`. At most one request output is high in any cycle.
- R9: `eraseBootDone` sends 0x06 and sets `progState`, which stays set until reset with all requests low.
- R10: Bytes other than the command codes are ignored in idle. All bytes are ignored while waiting, switching rate, erasing or in the programming state: no byte is sent and no flag changes.
- R11: Set flags in `selFlags` never clear except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| selOk | input | 1 | Validator verdict for the selection command now received |
| txValid | output | 1 | One-cycle strobe: send `txByte` |
| txByte | output | 8 | Response byte |
| waitReq | output | 1 | Request a one-bit-period wait at the current rate |
| waitDone | input | 1 | Wait finished |
| rateReq | output | 1 | Request the UART to load the rate named by `rateSel` |
| rateSel | output | 1 | 0 = earlier rate, 1 = newly selected rate |
| rateDone | input | 1 | UART has loaded the rate |
| eraseUserReq | output | 1 | Erase request for the user area |
| eraseUserDone | input | 1 | User area erased |
| eraseBootReq | output | 1 | Erase request for the user boot area |
| eraseBootDone | input | 1 | User boot area erased |
| selFlags | output | 3 | Sticky done flags: bit 0 target, bit 1 clock mode, bit 2 rate |
| progState | output | 1 | Programming/erasing state entered |

## Verification
The checker watches the following on every cycle:
- No more than one request output is high at a time.
- The boot-area erase starts only after the user-area erase completes.
- A switch to the new rate starts only after the wait has finished.
- The wait begins together with an acknowledge sent at the old rate.
- The rate falls back only after a wrong confirmation byte.
- The flags never clear.
- The programming state is final.

Only the directed scenarios show the exact response byte for each command, and the refusal of 0x40 while a step is missing. They also show the full revert path and that stray bytes are ignored. These depend on specific byte sequences and counts of done pulses.

// File: rtl/bch_pkg.sv
package bch_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 3;

  localparam logic [BYTE_W-1:0] CODE_DEV  = 8'h10;
  localparam logic [BYTE_W-1:0] CODE_CLK  = 8'h11;
  localparam logic [BYTE_W-1:0] CODE_RATE = 8'h3F;
  localparam logic [BYTE_W-1:0] CODE_PROG = 8'h40;
  localparam logic [BYTE_W-1:0] CODE_ACK  = 8'h06;
  localparam logic [BYTE_W-1:0] CODE_ERR  = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SWITCH, ST_CONFIRM,
    ST_REVERT, ST_ERASE_USER, ST_ERASE_BOOT, ST_PROG
  } bchState_e;

  typedef struct packed {
    logic sendAck;
    logic sendErr;
    logic setDev;
    logic setClk;
    logic setRate;
    logic rateNew;
    logic rateOld;
    logic enterProg;
  } bchStrobe_t;
endpackage

// File: rtl/bch_ctrl.sv
module bch_ctrl
  import bch_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_DEV  = CODE_DEV,
  parameter logic [BYTE_W-1:0] CMD_CLK  = CODE_CLK,
  parameter logic [BYTE_W-1:0] CMD_RATE = CODE_RATE,
  parameter logic [BYTE_W-1:0] CMD_PROG = CODE_PROG,
  parameter logic [BYTE_W-1:0] ACK_VAL  = CODE_ACK
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              selOk,
  input  logic              allSel,
  input  logic              waitDone,
  input  logic              rateDone,
  input  logic              eraseUserDone,
  input  logic              eraseBootDone,
  output bchStrobe_t        stb,
  output logic              waitReq,
  output logic              rateReq,
  output logic              eraseUserReq,
  output logic              eraseBootReq
);
  bchState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    case (state)
      ST_IDLE: begin
        if (rxValid) begin
          if (rxByte == CMD_DEV) begin
            stb.sendAck = selOk;
            stb.sendErr = !selOk;
            stb.setDev  = selOk;
          end else if (rxByte == CMD_CLK) begin
            stb.sendAck = selOk;
            stb.sendErr = !selOk;
            stb.setClk  = selOk;
          end else if (rxByte == CMD_RATE) begin
            stb.sendAck = selOk;
            stb.sendErr = !selOk;
            if (selOk) nextState = ST_WAIT;
          end else if (rxByte == CMD_PROG) begin
            stb.sendErr = !allSel;
            if (allSel) nextState = ST_ERASE_USER;
          end
        end
      end
      ST_WAIT: begin
        if (waitDone) begin
          stb.rateNew = 1'b1;
          nextState = ST_SWITCH;
        end
      end
      ST_SWITCH: begin
        if (rateDone) nextState = ST_CONFIRM;
      end
      ST_CONFIRM: begin
        if (rxValid) begin
          if (rxByte == ACK_VAL) begin
            stb.sendAck = 1'b1;
            stb.setRate = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.rateOld = 1'b1;
            nextState = ST_REVERT;
          end
        end
      end
      ST_REVERT: begin
        if (rateDone) begin
          stb.sendErr = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_ERASE_USER: begin
        if (eraseUserDone) nextState = ST_ERASE_BOOT;
      end
      ST_ERASE_BOOT: begin
        if (eraseBootDone) begin
          stb.sendAck = 1'b1;
          stb.enterProg = 1'b1;
          nextState = ST_PROG;
        end
      end
      default: nextState = state;
    endcase
  end

  assign waitReq      = (state == ST_WAIT);
  assign rateReq      = (state == ST_SWITCH) || (state == ST_REVERT);
  assign eraseUserReq = (state == ST_ERASE_USER);
  assign eraseBootReq = (state == ST_ERASE_BOOT);
endmodule

// File: rtl/bch_dpath.sv
module bch_dpath
  import bch_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ACK_VAL = CODE_ACK,
  parameter logic [BYTE_W-1:0] ERR_VAL = CODE_ERR
) (
  input  logic              clk,
  input  logic              rstN,
  input  bchStrobe_t        stb,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              rateSel,
  output logic [FLAG_N-1:0] selFlags,
  output logic              allSel,
  output logic              progState
);
  logic [FLAG_N-1:0] flagSet;
  assign flagSet = {stb.setRate, stb.setClk, stb.setDev};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= stb.sendAck | stb.sendErr;
      if (stb.sendErr)      txByte <= ERR_VAL;
      else if (stb.sendAck) txByte <= ACK_VAL;
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)           selFlags[i] <= 1'b0;
      else if (flagSet[i]) selFlags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateSel   <= 1'b0;
      progState <= 1'b0;
    end else begin
      if (stb.rateNew)      rateSel <= 1'b1;
      else if (stb.rateOld) rateSel <= 1'b0;
      if (stb.enterProg) progState <= 1'b1;
    end
  end

  assign allSel = &selFlags;
endmodule

// File: rtl/boot_handshake.sv
module boot_handshake
  import bch_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_DEV  = CODE_DEV,
  parameter logic [BYTE_W-1:0] CMD_CLK  = CODE_CLK,
  parameter logic [BYTE_W-1:0] CMD_RATE = CODE_RATE,
  parameter logic [BYTE_W-1:0] CMD_PROG = CODE_PROG,
  parameter logic [BYTE_W-1:0] ACK_VAL  = CODE_ACK,
  parameter logic [BYTE_W-1:0] ERR_VAL  = CODE_ERR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              selOk,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              waitReq,
  input  logic              waitDone,
  output logic              rateReq,
  output logic              rateSel,
  input  logic              rateDone,
  output logic              eraseUserReq,
  input  logic              eraseUserDone,
  output logic              eraseBootReq,
  input  logic              eraseBootDone,
  output logic [FLAG_N-1:0] selFlags,
  output logic              progState
);
  bchStrobe_t stb;
  logic allSel;

  bch_ctrl #(
    .CMD_DEV(CMD_DEV), .CMD_CLK(CMD_CLK), .CMD_RATE(CMD_RATE),
    .CMD_PROG(CMD_PROG), .ACK_VAL(ACK_VAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .selOk(selOk), .allSel(allSel), .waitDone(waitDone),
    .rateDone(rateDone), .eraseUserDone(eraseUserDone),
    .eraseBootDone(eraseBootDone), .stb(stb), .waitReq(waitReq),
    .rateReq(rateReq), .eraseUserReq(eraseUserReq),
    .eraseBootReq(eraseBootReq)
  );

  bch_dpath #(.ACK_VAL(ACK_VAL), .ERR_VAL(ERR_VAL)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .txValid(txValid),
    .txByte(txByte), .rateSel(rateSel), .selFlags(selFlags),
    .allSel(allSel), .progState(progState)
  );
endmodule

// File: rtl/boot_handshake_chk.sv
module boot_handshake_chk
  import bch_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ACK_VAL = CODE_ACK
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [BYTE_W-1:0] rxByte,
  input logic              txValid,
  input logic [BYTE_W-1:0] txByte,
  input logic              waitReq,
  input logic              waitDone,
  input logic              rateReq,
  input logic              rateSel,
  input logic              eraseUserReq,
  input logic              eraseUserDone,
  input logic              eraseBootReq,
  input logic [FLAG_N-1:0] selFlags,
  input logic              progState
);
  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({waitReq, rateReq, eraseUserReq, eraseBootReq}));

  // R8
  erase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseBootReq) |-> $past(eraseUserDone) && $past(eraseUserReq));

  // R4
  switch_after_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rateReq) && rateSel) |-> $past(waitDone) && $past(waitReq));

  // R3
  ack_old_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitReq) |-> txValid && (txByte == ACK_VAL) && !rateSel);

  // R6
  revert_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rateSel) |-> $past(rxValid) && ($past(rxByte) != ACK_VAL));

  // R9
  prog_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    progState |=> progState && !eraseUserReq && !eraseBootReq && !rateReq && !waitReq);

  // R11
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selFlags & $past(selFlags)) == $past(selFlags));
endmodule

bind boot_handshake boot_handshake_chk #(.ACK_VAL(ACK_VAL)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
  .txValid(txValid), .txByte(txByte), .waitReq(waitReq),
  .waitDone(waitDone), .rateReq(rateReq), .rateSel(rateSel),
  .eraseUserReq(eraseUserReq), .eraseUserDone(eraseUserDone),
  .eraseBootReq(eraseBootReq), .selFlags(selFlags), .progState(progState)
);

// File: tb/tb_boot_handshake.sv
`timescale 1ns/1ps
module tb_boot_handshake;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic selOk = 1'b0;
  logic waitDone = 1'b0, rateDone = 1'b0;
  logic eraseUserDone = 1'b0, eraseBootDone = 1'b0;
  logic txValid, waitReq, rateReq, rateSel, eraseUserReq, eraseBootReq, progState;
  logic [7:0] txByte;
  logic [2:0] selFlags;

  int nRun = 0, nFail = 0;
  logic gotTx;
  logic [7:0] gotByte;

  always #2 clk = ~clk;

  boot_handshake dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .selOk(selOk),
    .txValid(txValid), .txByte(txByte), .waitReq(waitReq), .waitDone(waitDone),
    .rateReq(rateReq), .rateSel(rateSel), .rateDone(rateDone),
    .eraseUserReq(eraseUserReq), .eraseUserDone(eraseUserDone),
    .eraseBootReq(eraseBootReq), .eraseBootDone(eraseBootDone),
    .selFlags(selFlags), .progState(progState)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ok);
    rxValid = 1'b1; rxByte = b; selOk = ok;
    @(negedge clk);
    gotTx = txValid; gotByte = txByte;
    rxValid = 1'b0; selOk = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  function automatic int reqs();
    return {28'd0, waitReq, rateReq, eraseUserReq, eraseBootReq};
  endfunction

  task automatic tReset();
    check(!txValid, "R1 txValid", txValid, 0);
    check(selFlags == 0, "R1 flags", selFlags, 0);
    check(!rateSel && !progState, "R1 rate/prog", {rateSel, progState}, 0);
    check(reqs() == 0, "R1 requests", reqs(), 0);
  endtask

  task automatic tIgnore();
    sendByte(8'h55, 1'b1);
    check(!gotTx, "R10 unknown byte idle", gotTx, 0);
    check(selFlags == 0 && reqs() == 0, "R10 no state change", {selFlags, reqs()}, 0);
  endtask

  task automatic tSelReject();
    sendByte(8'h10, 1'b0);
    check(gotTx && gotByte == 8'hFF, "R2 dev reject err", gotByte, 8'hFF);
    check(selFlags[0] == 1'b0, "R2 dev flag clear", selFlags, 0);
  endtask

  task automatic tProgEarly(input logic [2:0] expFlags);
    sendByte(8'h40, 1'b0);
    check(gotTx && gotByte == 8'hFF, "R7 early prog err", gotByte, 8'hFF);
    check(reqs() == 0, "R7 no erase", reqs(), 0);
    @(negedge clk);
    check(reqs() == 0 && selFlags == expFlags, "R7 still idle", reqs(), 0);
  endtask

  task automatic tSelAccept();
    sendByte(8'h10, 1'b1);
    check(gotTx && gotByte == 8'h06, "R2 dev ack", gotByte, 8'h06);
    check(selFlags == 3'b001, "R2 dev flag", selFlags, 3'b001);
    sendByte(8'h11, 1'b1);
    check(gotTx && gotByte == 8'h06, "R2 clk ack", gotByte, 8'h06);
    check(selFlags == 3'b011, "R2 clk flag", selFlags, 3'b011);
    sendByte(8'h10, 1'b0);
    check(gotByte == 8'hFF && selFlags == 3'b011, "R11 flag kept after reject", selFlags, 3'b011);
  endtask

  task automatic tRateStart();
    sendByte(8'h3F, 1'b1);
    check(gotTx && gotByte == 8'h06, "R3 ack at old rate", gotByte, 8'h06);
    check(!rateSel && waitReq, "R3 wait starts, old rate", {rateSel, waitReq}, 1);
    repeat (3) @(negedge clk);
    sendByte(8'h06, 1'b1);
    check(!gotTx && waitReq && !rateReq, "R10 byte ignored during wait", {gotTx, waitReq}, 1);
    pulse(waitDone);
    check(rateSel && rateReq && !waitReq, "R4 switch requested", {rateSel, rateReq, waitReq}, 6);
    repeat (2) @(negedge clk);
    check(rateReq, "R4 rateReq held", rateReq, 1);
    pulse(rateDone);
    check(!rateReq && rateSel, "R4 rateReq released", {rateReq, rateSel}, 1);
  endtask

  task automatic tRateBad();
    tRateStart();
    sendByte(8'h07, 1'b1);
    check(!gotTx && !rateSel && rateReq, "R6 revert requested", {gotTx, rateSel, rateReq}, 1);
    @(negedge clk);
    check(!txValid && rateReq, "R6 wait revert done", {txValid, rateReq}, 1);
    pulse(rateDone);
    check(txValid && txByte == 8'hFF, "R6 error byte", txByte, 8'hFF);
    check(!selFlags[2] && !rateReq && !rateSel, "R6 flag clear", selFlags, 3'b011);
  endtask

  task automatic tRateGood();
    tRateStart();
    sendByte(8'h06, 1'b1);
    check(gotTx && gotByte == 8'h06, "R5 confirm response", gotByte, 8'h06);
    check(selFlags == 3'b111 && rateSel, "R5 rate flag", selFlags, 3'b111);
  endtask

  task automatic tProgFull();
    sendByte(8'h40, 1'b0);
    check(!gotTx && eraseUserReq && !eraseBootReq, "R8 user erase first", reqs(), 2);
    sendByte(8'h10, 1'b1);
    check(!gotTx && eraseUserReq, "R10 byte ignored during erase", gotTx, 0);
    pulse(eraseUserDone);
    check(!eraseUserReq && eraseBootReq && !txValid, "R8 boot erase second", reqs(), 1);
    repeat (2) @(negedge clk);
    check(eraseBootReq && !progState, "R8 boot erase held", reqs(), 1);
    pulse(eraseBootDone);
    check(txValid && txByte == 8'h06, "R9 ack after erase", txByte, 8'h06);
    check(progState && reqs() == 0, "R9 prog state", progState, 1);
    sendByte(8'h3F, 1'b1);
    check(!gotTx && progState && reqs() == 0, "R9 prog final, R10 ignored", {gotTx, progState}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIgnore();
    tSelReject();
    tProgEarly(3'b000);
    tSelAccept();
    tProgEarly(3'b011);
    tRateBad();
    tRateGood();
    tProgFull();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #20000;
    nRun++;
    nFail++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule